// File: doc/BRIEF.md
# Segmented Generalized Address Former

This block turns every memory reference of a processor into a two-part generalized address: a 14-bit segment number and an 18-bit word number. It holds the working state that such addresses are built from. That state is a procedure segment register, a program counter, eight index registers and four segment/word base pairs. The four pairs are used as argument, base, linkage and stack pointers.

For an instruction fetch the block emits the procedure segment together with the program counter. For a decoded instruction it computes an effective word number from the address field plus an optional index register. When the external flag is clear, that word number is paired with the procedure segment. When the flag is set, a 2-bit tag picks one base pair, the effective word number is added to the pair's word number, and the pair's segment is used unchanged. A transfer of control does not emit an address. It redirects the program counter, and for an intersegment transfer it also redirects the procedure segment. Every result appears on a registered output one cycle after the request.

Top module: `segaddr_former`

## Requirements
- R1: After reset, ga_valid is 0 and every register (procedure segment, program counter, index registers, base pairs) is zero, so the first fetch yields segment 0, word 0.
- R2: A cycle with fetch_req=1 and dec_valid=0 produces, one cycle later, ga_valid=1 and ga_is_fetch=1, with ga_seg equal to the procedure segment and ga_word equal to the program counter. A fetch leaves the program counter unchanged.
- R3: A decode with dec_xfer=0 and dec_ext=0 produces, one cycle later, ga_valid=1 and ga_is_fetch=0, with ga_seg equal to the procedure segment and ga_word equal to the effective word number.
- R4: A decode with dec_xfer=0 and dec_ext=1 uses base pair dec_tag (0 argument, 1 base, 2 linkage, 3 stack). ga_seg is that pair's segment and ga_word is the pair's word number plus the effective word number.
- R5: The effective word number is dec_addr when dec_xsel=0, and dec_addr plus index register X(n-1) when dec_xsel=n for n from 1 to 8. All word additions wrap modulo 2^18.
- R6: Each decode with dec_xfer=0 advances the program counter by one, wrapping modulo 2^18.
- R7: A decode with dec_xfer=1 gives ga_valid=0 in the next cycle. It loads the program counter with the computed word number. When dec_ext=1, it also loads the procedure segment with the selected pair's segment. When dec_ext=0, the procedure segment is kept.
- R8: With ld_en=1, ld_sel selects the target, and the new value is visible from the next cycle. Codes 0 to 7 load index register Xn from ld_word. Codes 8 to 11 load base pair (ld_sel-8) from ld_seg and ld_word. Code 12 loads the procedure segment from ld_seg. Code 13 loads the program counter from ld_word. Codes 14 and 15 change nothing.
- R9: When a decode and a load fall in the same cycle, the address is formed from the values held before the load. A load of the program counter or the procedure segment overrides the advance or transfer made by that decode.
- R10: When fetch_req and dec_valid are both 1, the decode is served and the fetch request is ignored, so ga_is_fetch=0 in the next cycle.
- R11: A cycle with neither fetch_req nor dec_valid gives ga_valid=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Request an instruction-fetch address |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_xfer | input | 1 | Decoded instruction is a transfer of control |
| dec_ext | input | 1 | External flag: use a base pair |
| dec_tag | input | 2 | Base pair selector |
| dec_xsel | input | 4 | Index selector, 0 means none, n selects X(n-1) |
| dec_addr | input | 18 | Instruction address field |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 4 | Load target code |
| ld_seg | input | 14 | Segment value to load |
| ld_word | input | 18 | Word value to load |
| ga_valid | output | 1 | Generalized address valid |
| ga_is_fetch | output | 1 | 1 for an instruction fetch, 0 for a data reference |
| ga_seg | output | 14 | Segment number |
| ga_word | output | 18 | Word number |

## Verification
A register load can land in the same cycle as a decode that reads that register or that also writes the program counter. The bench provokes this in two ways. It loads an index register while a decode uses that register, and it loads the program counter while a decode advances it. It judges the outcome in two places: the address of the overlapping decode must carry the old index value, and a later fetch must show the loaded program counter rather than the advanced one. A fetch request raised together with a decode is also checked, and the data reference must be the one that is emitted.

// File: rtl/segaddr_former.sv
module segaddr_former #(
  parameter int SEG_W  = 14,
  parameter int WORD_W = 18,
  parameter int NIDX   = 8,
  parameter int NBASE  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fetch_req,
  input  logic                           dec_valid,
  input  logic                           dec_xfer,
  input  logic                           dec_ext,
  input  logic [$clog2(NBASE)-1:0]       dec_tag,
  input  logic [$clog2(NIDX+1)-1:0]      dec_xsel,
  input  logic [WORD_W-1:0]              dec_addr,
  input  logic                           ld_en,
  input  logic [$clog2(NIDX+NBASE+2)-1:0] ld_sel,
  input  logic [SEG_W-1:0]               ld_seg,
  input  logic [WORD_W-1:0]              ld_word,
  output logic                           ga_valid,
  output logic                           ga_is_fetch,
  output logic [SEG_W-1:0]               ga_seg,
  output logic [WORD_W-1:0]              ga_word
);
  localparam int XSEL_W = $clog2(NIDX+1);
  localparam int LSEL_W = $clog2(NIDX+NBASE+2);
  localparam int LD_PBR = NIDX + NBASE;
  localparam int LD_PC  = LD_PBR + 1;

  logic [WORD_W-1:0] xr   [NIDX];
  logic [SEG_W-1:0]  bseg [NBASE];
  logic [WORD_W-1:0] bwrd [NBASE];
  logic [SEG_W-1:0]  pbr;
  logic [WORD_W-1:0] pc;

  logic [WORD_W-1:0] xval, ea, eword;
  logic [SEG_W-1:0]  eseg;

  always_comb begin
    xval = '0;
    for (int i = 0; i < NIDX; i++)
      if (dec_xsel == XSEL_W'(i + 1)) xval = xr[i];
  end

  assign ea    = dec_addr + xval;
  assign eword = dec_ext ? bwrd[dec_tag] + ea : ea;
  assign eseg  = dec_ext ? bseg[dec_tag] : pbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pbr <= '0;
      pc  <= '0;
      for (int i = 0; i < NIDX; i++) xr[i] <= '0;
      for (int i = 0; i < NBASE; i++) begin
        bseg[i] <= '0;
        bwrd[i] <= '0;
      end
    end else begin
      if (dec_valid) begin
        if (dec_xfer) begin
          pc <= eword;
          if (dec_ext) pbr <= eseg;
        end else begin
          pc <= pc + 1'b1;
        end
      end
      if (ld_en) begin
        for (int i = 0; i < NIDX; i++)
          if (ld_sel == LSEL_W'(i)) xr[i] <= ld_word;
        for (int i = 0; i < NBASE; i++)
          if (ld_sel == LSEL_W'(NIDX + i)) begin
            bseg[i] <= ld_seg;
            bwrd[i] <= ld_word;
          end
        if (ld_sel == LSEL_W'(LD_PBR)) pbr <= ld_seg;
        if (ld_sel == LSEL_W'(LD_PC))  pc  <= ld_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ga_valid    <= 1'b0;
      ga_is_fetch <= 1'b0;
      ga_seg      <= '0;
      ga_word     <= '0;
    end else begin
      ga_valid    <= dec_valid ? !dec_xfer : fetch_req;
      ga_is_fetch <= !dec_valid;
      ga_seg      <= dec_valid ? eseg : pbr;
      ga_word     <= dec_valid ? eword : pc;
    end
  end

  // R2
  fetch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !dec_valid |=> ga_valid && ga_is_fetch && ga_seg == $past(pbr) && ga_word == $past(pc));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_xfer && !(ld_en && ld_sel == LSEL_W'(LD_PC)) |=> pc == $past(pc) + 1'b1);

  // R7
  xfer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_xfer |=> !ga_valid);

  // R3
  internal_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_xfer && !dec_ext |=> ga_valid && !ga_is_fetch && ga_seg == $past(pbr));

  // R10
  decode_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && fetch_req |=> !ga_is_fetch);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid && !fetch_req |=> !ga_valid);
endmodule

// File: tb/segaddr_former_bench.sv
module segaddr_former_bench;
  logic clk = 0, rst_n = 0;
  logic fetch_req = 0, dec_valid = 0, dec_xfer = 0, dec_ext = 0, ld_en = 0;
  logic [1:0] dec_tag = 0;
  logic [3:0] dec_xsel = 0, ld_sel = 0;
  logic [17:0] dec_addr = 0, ld_word = 0;
  logic [13:0] ld_seg = 0;
  logic ga_valid, ga_is_fetch;
  logic [13:0] ga_seg;
  logic [17:0] ga_word;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  segaddr_former u_segaddr_former (.*);

  task automatic tick();
    @(posedge clk); #1;
    fetch_req = 0; dec_valid = 0; dec_xfer = 0; dec_ext = 0; ld_en = 0;
  endtask

  task automatic expect_addr(string req, logic v, logic f, logic [13:0] s, logic [17:0] w);
    checks++;
    if (ga_valid !== v || (v && (ga_is_fetch !== f || ga_seg !== s || ga_word !== w))) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b %h:%h expected v=%0b f=%0b %h:%h",
               req, ga_valid, ga_is_fetch, ga_seg, ga_word, v, f, s, w);
    end
  endtask

  task automatic load(logic [3:0] sel, logic [13:0] s, logic [17:0] w);
    ld_en = 1; ld_sel = sel; ld_seg = s; ld_word = w; tick();
  endtask

  task automatic fetch_chk(string req, logic [13:0] s, logic [17:0] w);
    fetch_req = 1; tick(); expect_addr(req, 1, 1, s, w);
  endtask

  task automatic decode(logic x, logic e, logic [1:0] t, logic [3:0] xs, logic [17:0] a);
    dec_valid = 1; dec_xfer = x; dec_ext = e; dec_tag = t; dec_xsel = xs; dec_addr = a;
  endtask

  task automatic t_reset();
    expect_addr("R1 reset valid", 0, 0, 0, 0);
    fetch_chk("R1 reset regs", 14'h0, 18'h0);
  endtask

  task automatic t_load_fetch();
    load(12, 14'h1234, 0);
    load(13, 0, 18'h10);
    fetch_chk("R8 R2 fetch", 14'h1234, 18'h10);
    fetch_chk("R2 pc held", 14'h1234, 18'h10);
  endtask

  task automatic t_internal();
    load(2, 0, 18'd5);
    decode(0, 0, 0, 3, 18'd100); tick();
    expect_addr("R3 R5 indexed", 1, 0, 14'h1234, 18'd105);
    decode(0, 0, 0, 0, 18'd100); tick();
    expect_addr("R5 no index", 1, 0, 14'h1234, 18'd100);
    fetch_chk("R6 advance", 14'h1234, 18'h12);
  endtask

  task automatic t_external();
    for (int n = 0; n < 4; n++) load(4'(8 + n), 14'(16'h100 + n), 18'(32'h1000 * (n + 1)));
    for (int n = 0; n < 4; n++) begin
      decode(0, 1, 2'(n), 0, 18'd7); tick();
      expect_addr("R4 base pair", 1, 0, 14'(16'h100 + n), 18'(32'h1000 * (n + 1) + 7));
    end
    load(11, 14'h0333, 18'h3FFFF);
    decode(0, 1, 3, 3, 18'd2); tick();
    expect_addr("R5 wrap", 1, 0, 14'h0333, 18'd6);
    fetch_chk("R6 pc after ext", 14'h1234, 18'h17);
  endtask

  task automatic t_xfer();
    decode(1, 0, 0, 0, 18'h200); tick();
    expect_addr("R7 no output", 0, 0, 0, 0);
    fetch_chk("R7 internal xfer", 14'h1234, 18'h200);
    decode(1, 1, 1, 0, 18'h10); tick();
    expect_addr("R7 no output ext", 0, 0, 0, 0);
    fetch_chk("R7 intersegment", 14'h0101, 18'h2010);
  endtask

  task automatic t_overlap();
    decode(0, 0, 0, 3, 18'd0); ld_en = 1; ld_sel = 2; ld_word = 18'd9; tick();
    expect_addr("R9 old index", 1, 0, 14'h0101, 18'd5);
    decode(0, 0, 0, 3, 18'd0); tick();
    expect_addr("R9 new index", 1, 0, 14'h0101, 18'd9);
    decode(0, 0, 0, 0, 18'd0); ld_en = 1; ld_sel = 13; ld_word = 18'h3000; tick();
    fetch_chk("R9 load beats advance", 14'h0101, 18'h3000);
    decode(0, 0, 0, 0, 18'h40); fetch_req = 1; tick();
    expect_addr("R10 decode wins", 1, 0, 14'h0101, 18'h40);
    load(13, 0, 18'h3FFFF);
    decode(0, 0, 0, 0, 18'd0); tick();
    fetch_chk("R6 pc wrap", 14'h0101, 18'h0);
  endtask

  task automatic t_ignore();
    load(14, 14'h3FFF, 18'h3FFFF);
    load(15, 14'h3FFF, 18'h3FFFF);
    fetch_chk("R8 unused codes", 14'h0101, 18'h0);
    decode(0, 1, 0, 1, 18'd0); tick();
    expect_addr("R8 unused codes pair", 1, 0, 14'h0100, 18'h1000);
    tick();
    expect_addr("R11 idle", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_load_fetch();
    t_internal();
    t_external();
    t_xfer();
    t_overlap();
    t_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule